// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that completes one instruction per clock. Each 32-bit instruction word is fetched from an internal program array, split into fields, and decoded into datapath controls. Those controls pick the destination register, the second ALU operand, the ALU function, register and memory write enables, the write-back source, and the next program counter (sequential, branch or jump). The datapath holds a 32-entry by 32-bit register file with two read ports and one write port, an ALU with a zero flag, an immediate extender, and a word-addressed data array.

The core is controlled by a two-state machine. In `ST_HALT` the program counter holds and a host port can write the program array and read or write the data array. In `ST_RUN` one instruction is executed on every rising edge. Transition `GO` (`ST_HALT` to `ST_RUN`) is taken on the edge where `run` is high. Transition `STOP` (`ST_RUN` to `ST_HALT`) is taken on the edge where `run` is low. Reset forces `ST_HALT`. A write-back port shows each register write in the cycle before the edge that commits it.

Top module: `sc_core`

## Requirements
- R1: Reset clears the program counter to 0, clears all registers to 0 and enters `ST_HALT`. While reset is held, `wb_en` is low.
- R2: Opcode 0 selects register format, with fields rs=[25:21], rt=[20:16], rd=[15:11], shamt=[10:6] and funct=[5:0]. The result is written to rd. The funct codes are: add=32, sub=34, and=36, or=37, xor=38, nor=39, and slt=42 (signed less-than, result 1 or 0).
- R3: The shift funct codes shift the rt operand. sll=0, srl=2 and sra=3 take the count from shamt. sllv=4, srlv=6 and srav=7 take the count from bits [4:0] of rs. sra and srav fill with the sign bit.
- R4: The immediate format is op=[31:26], rs=[25:21], rt=[20:16], imm=[15:0], and the result is written to rt. addi=8 and slti=10 sign-extend imm. andi=12, ori=13 and xori=14 zero-extend it.
- R5: lw=35 writes the data word at byte address rs+sext(imm) into rt. sw=43 stores rt at that address. The word index is address bits [7:2].
- R6: beq=4 branches when rs equals rt, and bne=5 branches when they differ. The target is pc+4+(sext(imm)<<2). Otherwise the next pc is pc+4.
- R7: j=2 sets pc to {pc+4 bits [31:28], instr[25:0], 2'b00}.
- R8: Register 0 always reads as zero. A write aimed at it changes nothing and does not raise `wb_en`.
- R9: An instruction with an unlisted opcode, or with opcode 0 and an unlisted funct, writes neither a register nor memory, and the next pc is pc+4.
- R10: In `ST_HALT` the pc holds, and the host port writes the program array (`host_dmem`=0) or the data array (`host_dmem`=1). `host_rdata` always shows data word `host_addr`.
- R11: In `ST_RUN` the pc advances on every edge and is always word aligned. `wb_en`, `wb_addr` and `wb_data` describe the register write committed at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to execute, low to halt |
| host_we | input | 1 | Host write strobe, acted on only when halted |
| host_dmem | input | 1 | Host target: 1 data array, 0 program array |
| host_addr | input | HOST_AW | Host word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Data array word at host_addr |
| pc_o | output | 32 | Current program counter (byte address) |
| wb_en | output | 1 | A register write happens at the next edge |
| wb_addr | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value being written |

## Verification
The assertions check, on every cycle, these invariants: the pc stays word aligned; the pc holds while halted; the pc steps by four on non-control-flow instructions; a store never writes a register; an unlisted opcode never enables a write; register 0 stays zero; and a subtraction of equal operands raises the zero flag. Only the bench's program shows the rest. That covers the arithmetic and shift results and the difference between sign and zero extension. It also covers load and store addressing, the backward loop with bne, the forward skips with beq and j, and the end contents of data memory read back through the host port.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_SRA
    } alu_op_e;

    typedef enum logic {
        ST_HALT,
        ST_RUN
    } core_state_e;

    typedef struct packed {
        logic    reg_dst;     // 1: rd, 0: rt
        logic    alu_src;     // 1: extended immediate
        logic    mem_to_reg;
        logic    reg_wr;
        logic    mem_wr;
        logic    branch;
        logic    branch_ne;
        logic    jump;
        logic    zero_ext;
        logic    shift_fixed; // count from shamt field
        alu_op_e alu_op;
    } ctrl_t;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_J     = 6'd2;
    localparam logic [5:0] OP_BEQ   = 6'd4;
    localparam logic [5:0] OP_BNE   = 6'd5;
    localparam logic [5:0] OP_ADDI  = 6'd8;
    localparam logic [5:0] OP_SLTI  = 6'd10;
    localparam logic [5:0] OP_ANDI  = 6'd12;
    localparam logic [5:0] OP_ORI   = 6'd13;
    localparam logic [5:0] OP_XORI  = 6'd14;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SW    = 6'd43;

    localparam logic [5:0] FN_SLL  = 6'd0;
    localparam logic [5:0] FN_SRL  = 6'd2;
    localparam logic [5:0] FN_SRA  = 6'd3;
    localparam logic [5:0] FN_SLLV = 6'd4;
    localparam logic [5:0] FN_SRLV = 6'd6;
    localparam logic [5:0] FN_SRAV = 6'd7;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_AND  = 6'd36;
    localparam logic [5:0] FN_OR   = 6'd37;
    localparam logic [5:0] FN_XOR  = 6'd38;
    localparam logic [5:0] FN_NOR  = 6'd39;
    localparam logic [5:0] FN_SLT  = 6'd42;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_core_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (op)
            OP_RTYPE: begin
                ctrl.reg_dst = 1'b1;
                ctrl.reg_wr  = 1'b1;
                unique case (funct)
                    FN_SLL:  begin ctrl.alu_op = ALU_SLL; ctrl.shift_fixed = 1'b1; end
                    FN_SRL:  begin ctrl.alu_op = ALU_SRL; ctrl.shift_fixed = 1'b1; end
                    FN_SRA:  begin ctrl.alu_op = ALU_SRA; ctrl.shift_fixed = 1'b1; end
                    FN_SLLV: ctrl.alu_op = ALU_SLL;
                    FN_SRLV: ctrl.alu_op = ALU_SRL;
                    FN_SRAV: ctrl.alu_op = ALU_SRA;
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_XOR:  ctrl.alu_op = ALU_XOR;
                    FN_NOR:  ctrl.alu_op = ALU_NOR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_wr = 1'b0;
                endcase
            end
            OP_J: ctrl.jump = 1'b1;
            OP_BEQ, OP_BNE: begin
                ctrl.branch    = 1'b1;
                ctrl.branch_ne = (op == OP_BNE);
                ctrl.alu_op    = ALU_SUB;
            end
            OP_ADDI, OP_SLTI: begin
                ctrl.alu_src = 1'b1;
                ctrl.reg_wr  = 1'b1;
                ctrl.alu_op  = (op == OP_SLTI) ? ALU_SLT : ALU_ADD;
            end
            OP_ANDI, OP_ORI, OP_XORI: begin
                ctrl.alu_src  = 1'b1;
                ctrl.reg_wr   = 1'b1;
                ctrl.zero_ext = 1'b1;
                ctrl.alu_op   = (op == OP_ANDI) ? ALU_AND :
                                (op == OP_ORI)  ? ALU_OR  : ALU_XOR;
            end
            OP_LW: begin
                ctrl.alu_src    = 1'b1;
                ctrl.reg_wr     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctrl.alu_src = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] cnt;
    assign cnt = a[SHW-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_NOR: y = ~(a | b);
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLL: y = b << cnt;
            ALU_SRL: y = b >> cnt;
            ALU_SRA: y = $unsigned($signed(b) >>> cnt);
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

    // R6
    always_comb begin
        if (op == ALU_SUB && a == b)
            sub_equal_zero_chk: assert (zero);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREGS)-1:0] ra,
    input  logic [$clog2(NREGS)-1:0] rb,
    output logic [XLEN-1:0]          rdata_a,
    output logic [XLEN-1:0]          rdata_b,
    input  logic                     we,
    input  logic [$clog2(NREGS)-1:0] wa,
    input  logic [XLEN-1:0]          wdata
);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wdata;
        end
    end

    assign rdata_a = (ra == '0) ? '0 : regs[ra];
    assign rdata_b = (rb == '0) ? '0 : regs[rb];

    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int HOST_AW    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               host_we,
    input  logic               host_dmem,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic [31:0]        pc_o,
    output logic               wb_en,
    output logic [4:0]         wb_addr,
    output logic [31:0]        wb_data
);

    localparam int XLEN = 32;
    localparam int IAW  = $clog2(IMEM_WORDS);
    localparam int DAW  = $clog2(DMEM_WORDS);

    core_state_e state, state_nx;
    logic        running;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // transitions GO and STOP
    always_comb begin
        unique case (state)
            ST_HALT: state_nx = run ? ST_RUN : ST_HALT;
            ST_RUN:  state_nx = run ? ST_RUN : ST_HALT;
            default: state_nx = ST_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        unique case (state)
            ST_RUN:  running = 1'b1;
            default: running = 1'b0;
        endcase
    end

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];
    logic [XLEN-1:0] pc, pc_plus4, br_target, j_target, pc_nx;
    logic [XLEN-1:0] instr;

    assign instr = imem[pc[IAW+1:2]];

    logic [5:0]  f_op, f_funct;
    logic [4:0]  f_rs, f_rt, f_rd, f_shamt;
    logic [15:0] f_imm;

    assign f_op    = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_shamt = instr[10:6];
    assign f_funct = instr[5:0];
    assign f_imm   = instr[15:0];

    ctrl_t ctrl;

    sc_decoder u_dec (
        .op    (f_op),
        .funct (f_funct),
        .ctrl  (ctrl)
    );

    logic [XLEN-1:0] rs_data, rt_data, imm_sext, imm_ext;
    logic [XLEN-1:0] alu_a, alu_b, alu_y, load_data;
    logic            alu_zero, reg_we, take_br;
    logic [4:0]      wr_reg;

    assign imm_sext = {{(XLEN-16){f_imm[15]}}, f_imm};
    assign imm_ext  = ctrl.zero_ext ? {{(XLEN-16){1'b0}}, f_imm} : imm_sext;
    assign wr_reg   = ctrl.reg_dst ? f_rd : f_rt;
    assign reg_we   = running && ctrl.reg_wr;

    sc_regfile #(.XLEN(XLEN), .NREGS(32)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra      (f_rs),
        .rb      (f_rt),
        .rdata_a (rs_data),
        .rdata_b (rt_data),
        .we      (reg_we),
        .wa      (wr_reg),
        .wdata   (wb_data)
    );

    assign alu_a = ctrl.shift_fixed ? {{(XLEN-5){1'b0}}, f_shamt} : rs_data;
    assign alu_b = ctrl.alu_src ? imm_ext : rt_data;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign load_data = dmem[alu_y[DAW+1:2]];
    assign wb_data   = ctrl.mem_to_reg ? load_data : alu_y;
    assign wb_addr   = wr_reg;
    assign wb_en     = reg_we && (wr_reg != 5'd0);

    // next pc
    assign pc_plus4  = pc + 32'd4;
    assign br_target = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_br   = ctrl.branch && (alu_zero ^ ctrl.branch_ne);

    always_comb begin
        if (ctrl.jump)    pc_nx = j_target;
        else if (take_br) pc_nx = br_target;
        else              pc_nx = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= '0;
        else if (running) pc <= pc_nx;
    end

    assign pc_o = pc;

    // memories
    always_ff @(posedge clk) begin
        if (!running && host_we && !host_dmem)
            imem[host_addr[IAW-1:0]] <= host_wdata;
    end

    always_ff @(posedge clk) begin
        if (running && ctrl.mem_wr)
            dmem[alu_y[DAW+1:2]] <= rt_data;
        else if (!running && host_we && host_dmem)
            dmem[host_addr[DAW-1:0]] <= host_wdata;
    end

    assign host_rdata = dmem[host_addr[DAW-1:0]];

    // R11
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    // R10
    halt_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> $stable(pc));

    // R11
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ctrl.branch && !ctrl.jump) |=> (pc == $past(pc) + 32'd4));

    // R5
    store_no_regwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.mem_wr && ctrl.reg_wr));

    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_op inside {6'd0, 6'd2, 6'd4, 6'd5, 6'd8, 6'd10, 6'd12, 6'd13,
                       6'd14, 6'd35, 6'd43}) |-> (!ctrl.reg_wr && !ctrl.mem_wr));

endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        host_we = 1'b0;
    logic        host_dmem = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, pc_o, wb_data;
    logic        wb_en;
    logic [4:0]  wb_addr;

    always #2.5 clk = ~clk;

    sc_core i_sc_core (
        .clk(clk), .rst_n(rst_n), .run(run),
        .host_we(host_we), .host_dmem(host_dmem), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pc_o(pc_o),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [4:0]  a;
        logic [31:0] d;
        string       req;
    } exp_t;
    exp_t sb[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_wb(input int a, input logic [31:0] d, input string req);
        exp_t e;
        e.a = a[4:0]; e.d = d; e.req = req;
        sb.push_back(e);
    endtask

    // monitor side
    always @(negedge clk) begin
        if (rst_n && wb_en) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected write actual=r%0d:%h expected=none", wb_addr, wb_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " addr"}, {27'd0, wb_addr}, {27'd0, e.a});
                check({e.req, " data"}, wb_data, e.d);
            end
        end
    end

    function automatic logic [31:0] rt_i(int fn, int rs, int rt, int rd, int sh);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction

    function automatic logic [31:0] im_i(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic host_write(input bit to_dmem, input int addr, input logic [31:0] d);
        host_dmem = to_dmem; host_addr = addr[5:0]; host_wdata = d; host_we = 1'b1;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    logic [31:0] prog [39];

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        prog[0]  = im_i(8, 0, 8, 100);
        prog[1]  = im_i(8, 0, 9, -3);
        prog[2]  = rt_i(32, 8, 9, 10, 0);
        prog[3]  = rt_i(34, 9, 8, 11, 0);
        prog[4]  = im_i(13, 0, 12, 'hF0F0);
        prog[5]  = im_i(12, 9, 13, 'hFF00);
        prog[6]  = im_i(14, 12, 14, 'hFFFF);
        prog[7]  = rt_i(36, 12, 9, 15, 0);
        prog[8]  = rt_i(37, 12, 14, 16, 0);
        prog[9]  = rt_i(38, 9, 8, 17, 0);
        prog[10] = rt_i(39, 8, 0, 18, 0);
        prog[11] = rt_i(42, 9, 8, 19, 0);
        prog[12] = im_i(10, 8, 20, -1);
        prog[13] = rt_i(0, 0, 8, 21, 4);
        prog[14] = rt_i(2, 0, 9, 22, 28);
        prog[15] = rt_i(3, 0, 9, 23, 1);
        prog[16] = im_i(8, 0, 24, 3);
        prog[17] = rt_i(4, 24, 8, 25, 0);
        prog[18] = rt_i(6, 24, 9, 26, 0);
        prog[19] = rt_i(7, 24, 11, 27, 0);
        prog[20] = rt_i(32, 8, 8, 0, 0);
        prog[21] = rt_i(32, 0, 8, 1, 0);
        prog[22] = im_i(63, 8, 2, 5);
        prog[23] = rt_i(1, 8, 8, 3, 0);
        prog[24] = im_i(43, 0, 10, 8);
        prog[25] = im_i(43, 8, 21, -96);
        prog[26] = im_i(35, 0, 2, 8);
        prog[27] = im_i(35, 0, 3, 4);
        prog[28] = im_i(8, 0, 4, 0);
        prog[29] = im_i(8, 0, 5, 0);
        prog[30] = im_i(8, 4, 4, 1);
        prog[31] = rt_i(32, 5, 4, 5, 0);
        prog[32] = im_i(5, 4, 24, -3);
        prog[33] = im_i(4, 4, 24, 1);
        prog[34] = im_i(8, 0, 6, 99);
        prog[35] = {6'd2, 26'd37};
        prog[36] = im_i(8, 0, 6, 55);
        prog[37] = im_i(43, 0, 5, 0);
        prog[38] = im_i(4, 0, 0, -1);

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 pc", pc_o, 32'd0);
        check("R1 wb_en", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wb_en after reset", {31'd0, wb_en}, 32'd0);

        // R10 host loading while halted
        for (int i = 0; i < 39; i++) host_write(1'b0, i, prog[i]);
        host_write(1'b1, 3, 32'hCAFE_F00D);
        check("R10 pc held while halted", pc_o, 32'd0);

        expect_wb(8,  32'd100,       "R4 addi");
        expect_wb(9,  32'hFFFF_FFFD, "R4 addi negative");
        expect_wb(10, 32'd97,        "R2 add");
        expect_wb(11, 32'hFFFF_FF99, "R2 sub");
        expect_wb(12, 32'h0000_F0F0, "R4 ori zero-ext");
        expect_wb(13, 32'h0000_FF00, "R4 andi zero-ext");
        expect_wb(14, 32'h0000_0F0F, "R4 xori");
        expect_wb(15, 32'h0000_F0F0, "R2 and");
        expect_wb(16, 32'h0000_FFFF, "R2 or");
        expect_wb(17, 32'hFFFF_FF99, "R2 xor");
        expect_wb(18, 32'hFFFF_FF9B, "R2 nor");
        expect_wb(19, 32'd1,         "R2 slt");
        expect_wb(20, 32'd0,         "R4 slti");
        expect_wb(21, 32'h0000_0640, "R3 sll");
        expect_wb(22, 32'h0000_000F, "R3 srl");
        expect_wb(23, 32'hFFFF_FFFE, "R3 sra");
        expect_wb(24, 32'd3,         "R4 addi");
        expect_wb(25, 32'h0000_0320, "R3 sllv");
        expect_wb(26, 32'h1FFF_FFFF, "R3 srlv");
        expect_wb(27, 32'hFFFF_FFF3, "R3 srav");
        // word 20 writes r0: no entry (R8); words 22 and 23 are unlisted (R9)
        expect_wb(1,  32'd100,       "R8 r0 reads zero");
        expect_wb(2,  32'd97,        "R5 lw after sw");
        expect_wb(3,  32'h0000_0640, "R5 lw negative offset");
        expect_wb(4,  32'd0,         "R2 loop init");
        expect_wb(5,  32'd0,         "R2 loop init");
        for (int k = 1; k <= 3; k++) begin
            expect_wb(4, k,           "R6 bne loop count");
            expect_wb(5, k*(k+1)/2,   "R6 bne loop sum");
        end

        run = 1'b1;
        for (int c = 0; c < 2000 && sb.size() != 0; c++) @(negedge clk);
        check("R11 all writes seen", sb.size(), 32'd0);
        repeat (10) @(negedge clk);
        check("R7 pc parked at self-branch", pc_o, 32'd152);

        run = 1'b0;
        repeat (2) @(negedge clk);
        begin
            logic [31:0] held;
            held = pc_o;
            repeat (4) @(negedge clk);
            check("R10 pc holds after stop", pc_o, held);
        end

        host_dmem = 1'b1;
        host_addr = 6'd0; #1; check("R6 R7 sw of loop sum", host_rdata, 32'd6);
        host_addr = 6'd1; #1; check("R5 sw at rs+sext(imm)", host_rdata, 32'h0000_0640);
        host_addr = 6'd2; #1; check("R5 sw word index", host_rdata, 32'd97);
        host_addr = 6'd3; #1; check("R10 host data preload", host_rdata, 32'hCAFE_F00D);
        host_addr = 6'd4; #1; check("R9 unlisted op stores nothing", host_rdata === 32'hxxxx_xxxx ? 32'd0 : host_rdata, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule